// File: doc/BRIEF.md
# Low-Voltage Data Retention Sequencer

This block sits between a system bus master and an external asynchronous static RAM. It steers the RAM through a supply dropout so that stored data survives. When the power monitor withdraws its power-good indication, the sequencer deselects the RAM at the very next clock edge. One cycle later it releases the buses and holds only the pin that keeps the memory in retention. While the supply sits at its low retention level, which can go down to about 2.0 V, the RAM is kept quiet.

When the supply is back at its operating level, the monitor pulses a restore indication. The sequencer then counts out a recovery window of at least 5 ms before it re-enables the buses and raises its ready flag. A parameter picks which of the two chip selects holds retention. With the active-high select held low, every other RAM input may float. With the active-low select held high, the active-high select is still driven to a rail, and only the address, data and strobe lines float. The bus drive enables follow that choice.

Top module: `retseq_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, ready_o is 0 and ram_we_n_o and ram_oe_n_o are 1. ram_cs_n_o is 1. ram_ce_o is 0 when the active-high select holds retention and 1 when the active-low select holds it.
- R2: In normal operation, each clock edge registers the system request onto the pins. The resulting values are ready_o=1, ram_ce_o=sys_sel_i, ram_cs_n_o=!sys_sel_i, ram_we_n_o=!sys_we_i and ram_oe_n_o=!sys_oe_i. csn_drv_o, ctl_drv_o and addr_drv_o are all 1, and data_drv_o=sys_sel_i&sys_we_i.
- R3: An edge in normal operation that samples pwr_good_i=0 has these effects on the pins at that same edge: ready_o=0, the RAM deselected (ram_cs_n_o=1, and ram_ce_o at its hold level), ram_we_n_o=ram_oe_n_o=1 and data_drv_o=0. csn_drv_o, ctl_drv_o and addr_drv_o stay 1 for this one deselect cycle.
- R4: When the active-high select holds retention, the following apply from one cycle after the deselect until recovery ends: ram_ce_o=0 is driven, and csn_drv_o, ctl_drv_o, addr_drv_o and data_drv_o are all 0.
- R5: When the active-low select holds retention, the same period has ram_cs_n_o=1 with csn_drv_o=1 and ram_ce_o=1 driven, while ctl_drv_o, addr_drv_o and data_drv_o are 0.
- R6: Retention is left only on an edge that samples both pwr_restore_i=1 and pwr_good_i=1. pwr_restore_i with pwr_good_i=0 has no effect, and pwr_good_i alone does not start recovery.
- R7: ready_o rises exactly N edges after the edge that sampled the restore, where N = ceil(CLK_HZ*RECOVER_US/1e6). Before that, ready_o stays 0 and ram_we_n_o and ram_oe_n_o stay 1.
- R8: If pwr_good_i is sampled 0 during recovery, the sequencer returns to retention. A later restore then waits the full N edges again.
- R9: sys_sel_i, sys_we_i and sys_oe_i have no effect on any output outside normal operation.
- R10: After reset is released with pwr_good_i=1, ready_o rises on the N-th edge without a restore pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Supply monitor: 1 while no dropout is pending |
| pwr_restore_i | input | 1 | Supply monitor: supply is back at operating level |
| sys_sel_i | input | 1 | System request to select the RAM |
| sys_we_i | input | 1 | System write request |
| sys_oe_i | input | 1 | System read (output enable) request |
| ram_ce_o | output | 1 | RAM active-high chip select |
| ram_cs_n_o | output | 1 | RAM active-low chip select |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| csn_drv_o | output | 1 | Drive enable for the active-low select pad |
| ctl_drv_o | output | 1 | Drive enable for the write and output enable pads |
| addr_drv_o | output | 1 | Drive enable for the address bus |
| data_drv_o | output | 1 | Drive enable for the data bus |
| ready_o | output | 1 | RAM may be accessed |

## Verification
The bench builds two copies side by side, one per retention pin choice, with CLK_HZ=1_000_000 and RECOVER_US=5000. With these values the window is 5000 cycles, so about ten full recoveries, interrupted ones included, fit in the run. Sharing the stimulus between the copies compares the two float patterns against each other on every cycle. The short window lets the bench check the exact edge on which ready_o rises, and it keeps restore pulses sent during a live dropout within reach.

// File: rtl/retseq_pkg.sv
package retseq_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_DESEL   = 2'd1,
    ST_RETAIN  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  typedef enum logic {
    HOLD_BY_HI_SEL = 1'b0,
    HOLD_BY_LO_SEL = 1'b1
  } hold_pin_e;

  typedef struct packed {
    logic ce;
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic csn_drv;
    logic ctl_drv;
    logic addr_drv;
    logic data_drv;
    logic ready;
  } pin_set_t;

endpackage

// File: rtl/retseq_timer.sv
module retseq_timer #(
  parameter int unsigned CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW   = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // cleared whenever recovery is not running, so every entry starts at zero
  always_ff @(posedge clk) begin
    if (rst || !run_i)       cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // the count only advances while recovery runs (R7)
  p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (run_i && cnt_q != LAST) |=> (!run_i || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/retseq_fsm.sv
module retseq_fsm
  import retseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_i,
  input  logic       pwr_restore_i,
  input  logic       done_i,
  output seq_state_e state_q_o,
  output seq_state_e state_d_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_ACTIVE:  if (!pwr_good_i) st_d = ST_DESEL;
      ST_DESEL:   st_d = ST_RETAIN;
      ST_RETAIN:  if (pwr_good_i && pwr_restore_i) st_d = ST_RECOVER;
      ST_RECOVER: begin
        if (!pwr_good_i)  st_d = ST_RETAIN;
        else if (done_i)  st_d = ST_ACTIVE;
      end
      default:    st_d = ST_RETAIN;
    endcase
  end

  // reset is treated as a fresh power-up: wait the recovery window first
  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RECOVER;
    else     st_q <= st_d;
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;

  p_stay_retained_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RETAIN && !(pwr_good_i && pwr_restore_i)) |=> st_q == ST_RETAIN);
endmodule

// File: rtl/retseq_pins.sv
module retseq_pins
  import retseq_pkg::*;
#(
  parameter hold_pin_e HOLD_PIN = HOLD_BY_HI_SEL
) (
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d_i,
  input  logic       sys_sel_i,
  input  logic       sys_we_i,
  input  logic       sys_oe_i,
  output pin_set_t   pins_o
);
  localparam logic HOLD_CE  = (HOLD_PIN == HOLD_BY_LO_SEL);
  localparam logic HOLD_CSD = (HOLD_PIN == HOLD_BY_LO_SEL);
  localparam pin_set_t QUIET = '{ce: HOLD_CE, cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                 csn_drv: HOLD_CSD, ctl_drv: 1'b0, addr_drv: 1'b0,
                                 data_drv: 1'b0, ready: 1'b0};

  pin_set_t nxt, pins_q;

  always_comb begin
    nxt = QUIET;
    case (state_d_i)
      ST_ACTIVE: begin
        nxt.ce       = sys_sel_i;
        nxt.cs_n     = !sys_sel_i;
        nxt.we_n     = !sys_we_i;
        nxt.oe_n     = !sys_oe_i;
        nxt.csn_drv  = 1'b1;
        nxt.ctl_drv  = 1'b1;
        nxt.addr_drv = 1'b1;
        nxt.data_drv = sys_sel_i && sys_we_i;
        nxt.ready    = 1'b1;
      end
      ST_DESEL: begin
        nxt.csn_drv  = 1'b1;
        nxt.ctl_drv  = 1'b1;
        nxt.addr_drv = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pins_q <= QUIET;
    else     pins_q <= nxt;
  end

  assign pins_o = pins_q;

  generate
    if (HOLD_PIN == HOLD_BY_HI_SEL) begin : g_hi_hold
      p_hi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !pins_q.csn_drv |-> (!pins_q.ce && !pins_q.ctl_drv && !pins_q.addr_drv && !pins_q.data_drv));
    end else begin : g_lo_hold
      p_lo_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !pins_q.ctl_drv |-> (pins_q.cs_n && pins_q.csn_drv && pins_q.ce && !pins_q.data_drv));
    end
  endgenerate
endmodule

// File: rtl/retseq_top.sv
module retseq_top
  import retseq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned RECOVER_US = 5000,
  parameter hold_pin_e   HOLD_PIN   = HOLD_BY_HI_SEL
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic pwr_restore_i,
  input  logic sys_sel_i,
  input  logic sys_we_i,
  input  logic sys_oe_i,
  output logic ram_ce_o,
  output logic ram_cs_n_o,
  output logic ram_we_n_o,
  output logic ram_oe_n_o,
  output logic csn_drv_o,
  output logic ctl_drv_o,
  output logic addr_drv_o,
  output logic data_drv_o,
  output logic ready_o
);
  localparam longint RCV_L = (longint'(CLK_HZ) * longint'(RECOVER_US) + 64'd999_999) / 64'd1_000_000;
  localparam int unsigned RCV_CYC = (RCV_L < 1) ? 1 : int'(RCV_L);

  seq_state_e st_q, st_d;
  logic       tmr_done;
  pin_set_t   pins;

  retseq_timer #(.CYCLES(RCV_CYC)) u_timer (
    .clk(clk), .rst(rst), .run_i(st_q == ST_RECOVER), .done_o(tmr_done)
  );

  retseq_fsm u_fsm (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .pwr_restore_i(pwr_restore_i),
    .done_i(tmr_done), .state_q_o(st_q), .state_d_o(st_d)
  );

  retseq_pins #(.HOLD_PIN(HOLD_PIN)) u_pins (
    .clk(clk), .rst(rst), .state_d_i(st_d), .sys_sel_i(sys_sel_i),
    .sys_we_i(sys_we_i), .sys_oe_i(sys_oe_i), .pins_o(pins)
  );

  assign ram_ce_o   = pins.ce;
  assign ram_cs_n_o = pins.cs_n;
  assign ram_we_n_o = pins.we_n;
  assign ram_oe_n_o = pins.oe_n;
  assign csn_drv_o  = pins.csn_drv;
  assign ctl_drv_o  = pins.ctl_drv;
  assign addr_drv_o = pins.addr_drv;
  assign data_drv_o = pins.data_drv;
  assign ready_o    = pins.ready;

  p_drop_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !pwr_good_i) |=> (!ready_o && ram_cs_n_o && ram_we_n_o && ram_oe_n_o && !data_drv_o));

  p_quiet_unready_r9: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (ram_we_n_o && ram_oe_n_o && ram_cs_n_o));

  p_ready_after_wait_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(tmr_done));

  p_drop_in_recover_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RECOVER && !pwr_good_i) |=> (st_q == ST_RETAIN && !ready_o));
endmodule

// File: tb/retseq_top_test.sv
module retseq_top_test;
  import retseq_pkg::*;

  localparam int CLK_HZ = 1_000_000;
  localparam int REC_US = 5000;
  localparam int N_EXP  = int'((longint'(CLK_HZ) * REC_US + 999_999) / 1_000_000);

  logic clk = 1'b0;
  logic rst = 1'b1, good = 1'b1, restore = 1'b0, sel = 1'b0, we = 1'b0, oe = 1'b0;
  logic [8:0] pa, pb;
  int tests = 0, fails = 0;
  int mst = 3, mcnt = 0;

  always #5 clk = ~clk;

  retseq_top #(.CLK_HZ(CLK_HZ), .RECOVER_US(REC_US), .HOLD_PIN(HOLD_BY_HI_SEL)) uut (
    .clk(clk), .rst(rst), .pwr_good_i(good), .pwr_restore_i(restore),
    .sys_sel_i(sel), .sys_we_i(we), .sys_oe_i(oe),
    .ram_ce_o(pa[8]), .ram_cs_n_o(pa[7]), .ram_we_n_o(pa[6]), .ram_oe_n_o(pa[5]),
    .csn_drv_o(pa[4]), .ctl_drv_o(pa[3]), .addr_drv_o(pa[2]), .data_drv_o(pa[1]), .ready_o(pa[0]));

  retseq_top #(.CLK_HZ(CLK_HZ), .RECOVER_US(REC_US), .HOLD_PIN(HOLD_BY_LO_SEL)) uut_b (
    .clk(clk), .rst(rst), .pwr_good_i(good), .pwr_restore_i(restore),
    .sys_sel_i(sel), .sys_we_i(we), .sys_oe_i(oe),
    .ram_ce_o(pb[8]), .ram_cs_n_o(pb[7]), .ram_we_n_o(pb[6]), .ram_oe_n_o(pb[5]),
    .csn_drv_o(pb[4]), .ctl_drv_o(pb[3]), .addr_drv_o(pb[2]), .data_drv_o(pb[1]), .ready_o(pb[0]));

  // expected pins {ce,cs_n,we_n,oe_n,csn_drv,ctl_drv,addr_drv,data_drv,ready}
  function automatic logic [8:0] exp_pins(int st, bit lo, logic s, logic w, logic o);
    case (st)
      0:       return {s, ~s, ~w, ~o, 3'b111, s & w, 1'b1};   // R2
      1:       return {lo, 8'b1111_1100};                      // R3
      default: return {lo, 3'b111, lo, 4'b0000};               // R4 / R5, R9
    endcase
  endfunction

  function automatic string tag(int st, bit lo);
    case (st)
      0:       return "R2";
      1:       return "R3";
      default: return lo ? "R5 R9" : "R4 R9";
    endcase
  endfunction

  task automatic check(bit cond, string req, int act, int expv);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one clock: update the requirement model, then compare both copies
  task automatic tick();
    logic [8:0] e;
    @(posedge clk);
    if (rst) begin mst = 3; mcnt = 0; end
    else case (mst)
      0: if (!good) mst = 1;
      1: mst = 2;
      2: if (good && restore) begin mst = 3; mcnt = 0; end
      default: if (!good) mst = 2;
               else if (mcnt == N_EXP - 1) mst = 0;
               else mcnt++;
    endcase
    #1;
    e = exp_pins(mst, 1'b0, sel, we, oe);
    check(pa == e, tag(mst, 1'b0), pa, e);
    e = exp_pins(mst, 1'b1, sel, we, oe);
    check(pb == e, tag(mst, 1'b1), pb, e);
  endtask

  task automatic rand_sys();
    sel = 1'($urandom); we = 1'($urandom); oe = 1'($urandom);
  endtask

  // count edges from the restore edge until ready
  task automatic recover_measure(output int n);
    good = 1'b1; restore = 1'b1; rand_sys();
    tick();
    restore = 1'b0;
    n = 0;
    while (!pa[0] && n < N_EXP + 5) begin
      rand_sys();
      tick();
      n++;
      if (!pa[0]) check(pa[6] && pa[5] && pb[6] && pb[5], "R7", {pa[6], pa[5]}, 3);
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) tick();
    // R1 reset state
    check(pa[0] == 0 && pa[7] && pa[6] && pa[5] && pa[8] == 0, "R1", pa, 9'h0E0);
    check(pb[0] == 0 && pb[7] && pb[6] && pb[5] && pb[8] == 1, "R1", pb, 9'h1F0);
    rst = 1'b0;
    // R10 ready after reset without restore
    n = 0;
    while (!pa[0] && n < N_EXP + 5) begin tick(); n++; end
    check(n == N_EXP, "R10", n, N_EXP);

    for (int it = 0; it < 6; it++) begin
      for (int k = 0; k < 20 + int'($urandom_range(40)); k++) begin rand_sys(); tick(); end
      // R3 drop with write and read requested
      sel = 1; we = 1; oe = 1; good = 1'b0;
      tick();
      check(pa[0] == 0 && pa[6] && pa[5] && !pa[1], "R3", pa, 9'h0FC);
      // R6 R9 restore while good is low, random requests
      for (int k = 0; k < 10; k++) begin
        rand_sys(); restore = 1'($urandom); tick();
      end
      restore = 1'b0;
      check(pa[0] == 0 && pb[0] == 0, "R6", {pa[0], pb[0]}, 0);
      if (it == 0) begin
        // R6 good alone does not start recovery
        good = 1'b1;
        for (int k = 0; k < N_EXP + 5; k++) begin rand_sys(); tick(); end
        check(pa[0] == 0, "R6", pa[0], 0);
      end
      if (it % 2 == 1) begin
        // R8 dropout mid-recovery restarts the wait
        good = 1'b1; restore = 1'b1; tick(); restore = 1'b0;
        for (int k = 0; k < 100 + int'($urandom_range(N_EXP - 200)); k++) begin rand_sys(); tick(); end
        good = 1'b0;
        repeat (3) tick();
        check(pa[0] == 0 && pa[3] == 0, "R8", pa, 9'h0E0);
        recover_measure(n);
        check(n == N_EXP, "R8", n, N_EXP);
      end else begin
        recover_measure(n);
        check(n == N_EXP, "R7", n, N_EXP);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule